// File: doc/BRIEF.md
# Text and Bitmap Pixel Pipeline

This block sits between the raster counters of a video timing generator and an external colour palette. For every pixel strobe it builds the display-RAM address, and in character mode also the glyph-ROM address. It collects the returned bytes and produces an 8-bit palette index together with a video enable that has been delayed to line up with that index. The RAM, the glyph ROM and the palette are outside the block. Their data inputs are sampled combinationally in the strobe cycle that presents the address.

In character mode a RAM byte holds a 7-bit glyph code and a one-bit attribute. The glyph row byte from the ROM is loaded into a shift register and leaves it most significant bit first. Four sources make up the colour nibble: the glyph bit, the attribute, a flash input, and an underline bit that drops on the bottom glyph row. In bitmap mode each RAM byte carries two 4-bit pixels. Every bitmap pixel lasts two strobes, and the `c0` input can be routed to a palette bit, so the palette contents decide between a 16-colour picture and a 4-colour picture at double width.

The column counter `col_i` splits into a character column (upper bits) and a pixel-in-cell position (low 3 bits). The line counter `line_i` splits into a character row (upper bits) and a glyph row (low 3 bits). Nothing advances without a strobe.

Top module: `vpix_pipe`

## Requirements
- R1: While `rst_n` is low, `pal_idx_o` and `vid_en_o` are 0 and the internal delay line is cleared.
- R2: With `gfx_mode_i`=0, `ram_addr_o` = {`page_i`, `line_i` upper bits, `col_i` upper bits}, leaving out the 3 low bits of each counter.
- R3: With `gfx_mode_i`=1, `ram_addr_o` = {`line_i`, `col_i` without its 2 low bits}, so each byte covers four strobes.
- R4: On a strobe with `col_i[2:0]`=0, `rom_addr_o` = {3'b111, low 7 bits of the RAM byte captured at the previous cell start, `line_i[2:0]`}. That captured code stays unchanged for the rest of the cell.
- R5: Character-mode colour nibble: bit 0 is the glyph bit (glyph byte bit 7 for cell pixel 0, down to bit 0 for pixel 7), bit 1 is RAM bit 7, bit 2 is `flash_i`, and bit 3 is 0 on glyph row 7 and 1 on every other row.
- R6: Bitmap-mode nibble: the byte fetched for a pixel column gives its upper nibble when `col_i[1]`=0 and its lower nibble when `col_i[1]`=1.
- R7: Upper palette bits: in character mode `pal_idx_o[7:5]`=`pal_page_i` and bit 4 = 0. In bitmap mode `pal_idx_o[7:6]`=`pal_page_i[2:1]`, bit 5 = `c0_i` as sampled on the strobe that registers the output, and bit 4 = 0.
- R8: The pixel for the column presented on strobe n is registered on strobe n+9 (one character of 8 plus one output stage). `vid_en_o` carries the `vid_en_i` of strobe n with the same delay.
- R9: Whenever `vid_en_o` is 0, `pal_idx_o` is 0.
- R10: A strobe with `disp_on_i`=0 (CPU owns the RAM) registers `vid_en_o`=0 and `pal_idx_o`=0.
- R11: A cycle with `pix_en_i`=0 changes neither `pal_idx_o` nor `vid_en_o`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel strobe; the pipeline advances only when it is high |
| col_i | input | COL_W+3 | Horizontal pixel counter |
| line_i | input | CROW_W+3 | Line counter |
| vid_en_i | input | 1 | Raw enable for the active picture area |
| disp_on_i | input | 1 | 1 = video owns the RAM, 0 = CPU owns it (blank) |
| gfx_mode_i | input | 1 | 0 = character mode, 1 = bitmap mode |
| page_i | input | 4 | Character-screen page in RAM |
| pal_page_i | input | 3 | Palette page select |
| flash_i | input | 1 | Slow flash signal |
| c0_i | input | 1 | Half-pixel phase for the double-width option |
| ram_data_i | input | 8 | Display RAM read data |
| rom_data_i | input | 8 | Glyph ROM read data |
| ram_addr_o | output | 4+CROW_W+COL_W | Display RAM address |
| rom_addr_o | output | 13 | Glyph ROM address |
| pal_idx_o | output | 8 | Palette index |
| vid_en_o | output | 1 | Delayed video enable |

## Verification
The bench builds the block with COL_W=3 and CROW_W=2, which gives 64-pixel lines and a 32-line frame. With lines that short, a run crosses line ends, glyph row 7, the wrap of the line counter from its top value back to zero, and the fetch that spans a line boundary within a few hundred strobes. A 9-bit address also lets a small arithmetic memory model in the bench stand in for the whole display RAM, so every pixel of every line is compared against an independent prediction.

// File: rtl/vpix_pkg.sv
package vpix_pkg;
    localparam int CELL_W  = 3;
    localparam int CELL    = 1 << CELL_W;
    localparam int BYTE_W  = 8;
    localparam int CODE_W  = 7;
    localparam int PAGE_W  = 4;
    localparam int PPAGE_W = 3;
    localparam int PAL_W   = 8;
    localparam int NIB_W   = 4;
    localparam int FONT_W  = 3;
    localparam int ROM_AW  = FONT_W + CODE_W + CELL_W;
    localparam logic [FONT_W-1:0] FONT_BASE = '1;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/vpix_addr.sv
module vpix_addr
    import vpix_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int CROW_W = 5,
    localparam int X_W    = COL_W + CELL_W,
    localparam int Y_W    = CROW_W + CELL_W,
    localparam int RAM_AW = PAGE_W + CROW_W + COL_W
) (
    input  logic              gfx_mode_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [X_W-1:0]    col_i,
    input  logic [Y_W-1:0]    line_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [ROM_AW-1:0] rom_addr_o
);
    logic [RAM_AW-1:0] txt_addr;
    logic [RAM_AW-1:0] bmp_addr;

    always_comb begin
        // character mode: page, character row, character column
        txt_addr = {page_i, line_i[Y_W-1:CELL_W], col_i[X_W-1:CELL_W]};
        // bitmap mode: every line, one byte per four pixel columns
        bmp_addr = {line_i, col_i[X_W-1:2]};
        ram_addr_o = gfx_mode_i ? bmp_addr : txt_addr;
        rom_addr_o = {FONT_BASE, code_i, line_i[CELL_W-1:0]};
    end
endmodule

// File: rtl/vpix_text.sv
module vpix_text
    import vpix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en_i,
    input  logic [CELL_W-1:0] cell_pos_i,
    input  logic [CELL_W-1:0] glyph_row_i,
    input  logic              flash_i,
    input  byte_t             ram_data_i,
    input  byte_t             rom_data_i,
    output logic [CODE_W-1:0] code_o,
    output nib_t              nib_o
);
    typedef struct packed {
        byte_t            code;
        logic [CELL-1:0]  shift;
        logic             attr;
        logic             uline;
    } txt_state_t;

    txt_state_t txt_d, txt_q;
    logic       cell_start;

    always_comb begin
        txt_d      = txt_q;
        cell_start = (cell_pos_i == '0);
        if (pix_en_i) begin
            if (cell_start) begin
                // glyph of previous cell enters the shifter,
                // code of this cell is captured for the next lookup
                txt_d.shift = rom_data_i;
                txt_d.attr  = txt_q.code[BYTE_W-1];
                txt_d.uline = (glyph_row_i != {CELL_W{1'b1}});
                txt_d.code  = ram_data_i;
            end else begin
                txt_d.shift = {txt_q.shift[CELL-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txt_q <= '0;
        else        txt_q <= txt_d;
    end

    assign code_o = txt_q.code[CODE_W-1:0];
    assign nib_o  = {txt_q.uline, flash_i, txt_q.attr, txt_q.shift[CELL-1]};

    // R4: the code that addresses the glyph ROM only moves at a cell start
    assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && cell_pos_i != '0) |=> $stable(txt_q.code));
endmodule

// File: rtl/vpix_gfx.sv
module vpix_gfx
    import vpix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en_i,
    input  logic [CELL_W-1:0] cell_pos_i,
    input  byte_t             ram_data_i,
    output nib_t              nib_o
);
    localparam int PER_CELL = CELL / 4;
    localparam int SH_W     = PER_CELL * BYTE_W;
    localparam int SEL_W    = CELL_W - 1;

    typedef struct packed {
        logic [PER_CELL-1:0][BYTE_W-1:0] grab;
        logic [SH_W-1:0]                 show;
    } gfx_state_t;

    gfx_state_t        gfx_d, gfx_q;
    logic [CELL_W-1:0] pos_m1;
    logic [SEL_W-1:0]  sel;

    always_comb begin
        gfx_d = gfx_q;
        if (pix_en_i) begin
            if (cell_pos_i[1:0] == 2'b00) begin
                gfx_d.grab[cell_pos_i[CELL_W-1:2]] = ram_data_i;
            end
            if (cell_pos_i == '0) begin
                // bytes of the previous cell move to the display stage
                gfx_d.show = {gfx_q.grab[0], gfx_q.grab[1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gfx_q <= '0;
        else        gfx_q <= gfx_d;
    end

    // the output stage registers pixel k on cell position k+1
    always_comb begin
        pos_m1 = cell_pos_i - 1'b1;
        sel    = pos_m1[CELL_W-1:1];
        nib_o  = '0;
        for (int i = 0; i < 2 * PER_CELL; i++) begin
            if (sel == SEL_W'(i)) nib_o = gfx_q.show[SH_W-1-NIB_W*i -: NIB_W];
        end
    end

    // R6: captured bytes stay put between their capture strobes
    assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && cell_pos_i[1:0] != 2'b00) |=> $stable(gfx_q.grab));
endmodule

// File: rtl/vpix_out.sv
module vpix_out
    import vpix_pkg::*;
#(
    parameter int DLY = CELL + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en_i,
    input  logic               vid_en_i,
    input  logic               disp_on_i,
    input  logic               gfx_mode_i,
    input  logic [PPAGE_W-1:0] pal_page_i,
    input  logic               c0_i,
    input  nib_t               txt_nib_i,
    input  nib_t               gfx_nib_i,
    output logic [PAL_W-1:0]   pal_idx_o,
    output logic               vid_en_o
);
    typedef struct packed {
        logic [DLY-1:0]   pipe;
        logic             ven;
        logic [PAL_W-1:0] pal;
    } out_state_t;

    out_state_t       out_d, out_q;
    logic [PAL_W-1:0] idx;

    always_comb begin
        out_d = out_q;
        if (gfx_mode_i) idx = {pal_page_i[PPAGE_W-1:1], c0_i, 1'b0, gfx_nib_i};
        else            idx = {pal_page_i, 1'b0, txt_nib_i};
        if (pix_en_i) begin
            out_d.pipe = {out_q.pipe[DLY-2:0], vid_en_i};
            out_d.ven  = out_q.pipe[DLY-1] & disp_on_i;
            out_d.pal  = out_d.ven ? idx : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pal_idx_o = out_q.pal;
    assign vid_en_o  = out_q.ven;

    // R9: blanked output carries index 0
    assert_blank_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.ven |-> (out_q.pal == '0));

    // R10: a strobe while the CPU owns the RAM blanks the output
    assert_cpu_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en_i && !disp_on_i) |=> !out_q.ven);

    // R11: outputs hold without a strobe
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en_i |=> ($stable(out_q.pal) && $stable(out_q.ven)));
endmodule

// File: rtl/vpix_pipe.sv
module vpix_pipe
    import vpix_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int CROW_W = 5,
    localparam int X_W    = COL_W + CELL_W,
    localparam int Y_W    = CROW_W + CELL_W,
    localparam int RAM_AW = PAGE_W + CROW_W + COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en_i,
    input  logic [X_W-1:0]     col_i,
    input  logic [Y_W-1:0]     line_i,
    input  logic               vid_en_i,
    input  logic               disp_on_i,
    input  logic               gfx_mode_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [PPAGE_W-1:0] pal_page_i,
    input  logic               flash_i,
    input  logic               c0_i,
    input  logic [BYTE_W-1:0]  ram_data_i,
    input  logic [BYTE_W-1:0]  rom_data_i,
    output logic [RAM_AW-1:0]  ram_addr_o,
    output logic [ROM_AW-1:0]  rom_addr_o,
    output logic [PAL_W-1:0]   pal_idx_o,
    output logic               vid_en_o
);
    logic [CODE_W-1:0] code;
    nib_t              txt_nib;
    nib_t              gfx_nib;

    vpix_addr #(.COL_W(COL_W), .CROW_W(CROW_W)) u_addr (
        .gfx_mode_i (gfx_mode_i),
        .page_i     (page_i),
        .col_i      (col_i),
        .line_i     (line_i),
        .code_i     (code),
        .ram_addr_o (ram_addr_o),
        .rom_addr_o (rom_addr_o)
    );

    vpix_text u_text (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en_i    (pix_en_i),
        .cell_pos_i  (col_i[CELL_W-1:0]),
        .glyph_row_i (line_i[CELL_W-1:0]),
        .flash_i     (flash_i),
        .ram_data_i  (ram_data_i),
        .rom_data_i  (rom_data_i),
        .code_o      (code),
        .nib_o       (txt_nib)
    );

    vpix_gfx u_gfx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en_i   (pix_en_i),
        .cell_pos_i (col_i[CELL_W-1:0]),
        .ram_data_i (ram_data_i),
        .nib_o      (gfx_nib)
    );

    vpix_out #(.DLY(CELL + 1)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en_i   (pix_en_i),
        .vid_en_i   (vid_en_i),
        .disp_on_i  (disp_on_i),
        .gfx_mode_i (gfx_mode_i),
        .pal_page_i (pal_page_i),
        .c0_i       (c0_i),
        .txt_nib_i  (txt_nib),
        .gfx_nib_i  (gfx_nib),
        .pal_idx_o  (pal_idx_o),
        .vid_en_o   (vid_en_o)
    );
endmodule

// File: tb/tb_vpix_pipe.sv
module tb_vpix_pipe;
    localparam int COL_W  = 3;
    localparam int CROW_W = 2;
    localparam int X_W    = COL_W + 3;
    localparam int Y_W    = CROW_W + 3;
    localparam int RAM_AW = 4 + CROW_W + COL_W;
    localparam int ROM_AW = 13;
    localparam int W      = 1 << X_W;
    localparam int LAT    = 9;
    localparam int NSCN   = 6;

    // {gfx, page[3:0], pal_page[2:0], flash, disp, gap, y0[4:0]}
    localparam logic [15:0] SCN [NSCN] = '{
        {1'b0, 4'h5, 3'd3, 1'b0, 1'b1, 1'b0, 5'd7},
        {1'b0, 4'hA, 3'd6, 1'b1, 1'b1, 1'b1, 5'd14},
        {1'b1, 4'h0, 3'd5, 1'b0, 1'b1, 1'b0, 5'd3},
        {1'b1, 4'hF, 3'd2, 1'b1, 1'b1, 1'b1, 5'd30},
        {1'b0, 4'h3, 3'd7, 1'b1, 1'b0, 1'b0, 5'd23},
        {1'b1, 4'h6, 3'd1, 1'b0, 1'b0, 1'b1, 5'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pix_en = 1'b0;
    logic [X_W-1:0]    col = '0;
    logic [Y_W-1:0]    line = '0;
    logic              vid_en = 1'b0;
    logic              disp_on = 1'b0;
    logic              gfx_mode = 1'b0;
    logic [3:0]        page = '0;
    logic [2:0]        pal_page = '0;
    logic              flash = 1'b0;
    logic              c0 = 1'b0;
    logic [7:0]        ram_data;
    logic [7:0]        rom_data;
    logic [RAM_AW-1:0] ram_addr;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        pal_idx;
    logic              ven_out;

    vpix_pipe #(.COL_W(COL_W), .CROW_W(CROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .pix_en_i(pix_en), .col_i(col), .line_i(line),
        .vid_en_i(vid_en), .disp_on_i(disp_on), .gfx_mode_i(gfx_mode),
        .page_i(page), .pal_page_i(pal_page), .flash_i(flash), .c0_i(c0),
        .ram_data_i(ram_data), .rom_data_i(rom_data), .ram_addr_o(ram_addr),
        .rom_addr_o(rom_addr), .pal_idx_o(pal_idx), .vid_en_o(ven_out)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] ram_f(input logic [RAM_AW-1:0] a);
        logic [15:0] t;
        t = (16'(a) * 16'd29) ^ (16'(a) >> 2) ^ 16'h005A;
        return t[7:0];
    endfunction

    function automatic logic [7:0] rom_f(input logic [ROM_AW-1:0] a);
        logic [15:0] t;
        t = (16'(a) * 16'd13) ^ (16'(a) >> 4);
        return t[7:0] ^ 8'hA5;
    endfunction

    assign ram_data = ram_f(ram_addr);
    assign rom_data = rom_f(rom_addr);

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // bench model state
    logic       ring_en [16];
    logic [3:0] ring_nib [16];
    int         s;
    logic [7:0] last_pal;
    logic       last_ven;
    logic [7:0] last_code;
    bit         have_code;

    function automatic logic [RAM_AW-1:0] taddr(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
        return {page, y[Y_W-1:3], x[X_W-1:3]};
    endfunction

    function automatic logic [RAM_AW-1:0] gaddr(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
        return {y, x[X_W-1:2]};
    endfunction

    function automatic logic [3:0] exp_nib(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
        logic [7:0] code, g, by;
        if (!gfx_mode) begin
            code = ram_f(taddr(x, y));
            g    = rom_f({3'b111, code[6:0], y[2:0]});
            return {y[2:0] != 3'd7, flash, code[7], g[3'd7 - x[2:0]]};
        end
        by = ram_f(gaddr(x, y));
        return x[1] ? by[3:0] : by[7:4];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        pix_en = 1'b0;
        #1;
        chk("R1 pal", 32'(pal_idx), 32'h0);
        chk("R1 ven", 32'(ven_out), 32'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        s = 0;
        have_code = 0;
        last_pal = '0;
        last_ven = 1'b0;
        for (int i = 0; i < 16; i++) begin
            ring_en[i]  = 1'b0;
            ring_nib[i] = '0;
        end
    endtask

    // called at a negedge; leaves at the next negedge
    task automatic cycle(input bit strobe, input logic [X_W-1:0] x,
                         input logic [Y_W-1:0] y, input logic raw);
        logic       e_en;
        logic [7:0] e_pal;
        string      tag;
        pix_en = strobe;
        col    = x;
        line   = y;
        vid_en = raw;
        c0     = strobe ? x[0] : ~x[0];
        #1;
        if (strobe) begin
            if (gfx_mode) chk("R3 ram_addr", 32'(ram_addr), 32'(gaddr(x, y)));
            else          chk("R2 ram_addr", 32'(ram_addr), 32'(taddr(x, y)));
            if (!gfx_mode && x[2:0] == 3'd0) begin
                if (have_code)
                    chk("R4 rom_addr", 32'(rom_addr), 32'({3'b111, last_code[6:0], y[2:0]}));
                last_code = ram_f(taddr(x, y));
                have_code = 1;
            end
            ring_en[s % 16]  = raw;
            ring_nib[s % 16] = exp_nib(x, y);
        end
        @(negedge clk);
        if (strobe) begin
            e_en  = 1'b0;
            e_pal = '0;
            if (s >= LAT) begin
                e_en = ring_en[(s - LAT) % 16] && disp_on;
                if (e_en) begin
                    if (gfx_mode) e_pal = {pal_page[2:1], x[0], 1'b0, ring_nib[(s - LAT) % 16]};
                    else          e_pal = {pal_page, 1'b0, ring_nib[(s - LAT) % 16]};
                end
            end
            chk("R8 vid_en", 32'(ven_out), 32'(e_en));
            if (!disp_on)   tag = "R10 blank";
            else if (!e_en) tag = "R9 blank";
            else if (gfx_mode) tag = "R6 nibble";
            else tag = "R5 nibble";
            chk(tag, 32'(pal_idx[3:0]), 32'(e_pal[3:0]));
            chk(e_en ? "R7 upper" : tag, 32'(pal_idx[7:4]), 32'(e_pal[7:4]));
            s++;
        end else begin
            chk("R11 hold pal", 32'(pal_idx), 32'(last_pal));
            chk("R11 hold ven", 32'(ven_out), 32'(last_ven));
        end
        last_pal = pal_idx;
        last_ven = ven_out;
    endtask

    task automatic run_line(input logic [Y_W-1:0] y, input bit gap, input bit cpu_window);
        for (int xi = 0; xi < W; xi++) begin
            if (cpu_window) disp_on = !(xi >= 20 && xi <= 30);
            cycle(1'b1, X_W'(xi), y, xi < W - 8);
            if (gap) cycle(1'b0, X_W'(xi + 3), y + 5'd1, 1'b1);
        end
    endtask

    task automatic flush(input logic [Y_W-1:0] y);
        for (int xi = 0; xi < LAT + 1; xi++) cycle(1'b1, X_W'(xi), y, 1'b0);
    endtask

    initial begin
        logic [15:0] v;
        logic [Y_W-1:0] y0;
        // table-driven runs, two lines each
        for (int k = 0; k < NSCN; k++) begin
            v = SCN[k];
            do_reset();
            gfx_mode = v[15];
            page     = v[14:11];
            pal_page = v[10:8];
            flash    = v[7];
            disp_on  = v[6];
            y0       = v[4:0];
            run_line(y0, v[5], 1'b0);
            run_line(y0 + 5'd1, v[5], 1'b0);
            flush(y0 + 5'd2);
        end
        // directed: CPU takes the RAM in the middle of a text line (R10)
        do_reset();
        gfx_mode = 1'b0; page = 4'h9; pal_page = 3'd4; flash = 1'b1; disp_on = 1'b1;
        run_line(5'd15, 1'b0, 1'b1);
        disp_on = 1'b1;
        flush(5'd16);
        // directed: reset arriving mid-picture clears outputs (R1)
        do_reset();
        gfx_mode = 1'b1; page = 4'h2; pal_page = 3'd7; disp_on = 1'b1;
        for (int xi = 0; xi < 30; xi++) cycle(1'b1, X_W'(xi), 5'd9, 1'b1);
        chk("R1 precondition ven", 32'(ven_out), 32'h1);
        do_reset();
        chk("R1 pal after reset", 32'(pal_idx), 32'h0);
        chk("R1 ven after reset", 32'(ven_out), 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule